// File: doc/BRIEF.md
# 19-bit Floating-Point Adder-Subtractor

This block is a purely combinational unit that adds or subtracts two 19-bit floating-point numbers. Each number has a sign bit, an 8-bit biased exponent and a 10-bit fraction, which gives the dynamic range of single precision with a much shorter significand. A single control input picks addition or subtraction. The block returns the 19-bit result together with four exception flags: invalid, overflow, underflow and inexact.

Internally the unit unpacks both operands and puts the hidden bit back. It then shifts the operand of smaller magnitude right to the larger exponent, keeping the bits that fall off as a sticky indication. Next it adds or subtracts the magnitudes and renormalizes in either direction, without going below the smallest exponent. The last steps are rounding and repacking. Rounding is to nearest and looks only at the first bit below the kept fraction: when that bit is set, one is added.

Denormal operands and denormal results are handled as gradual underflow. Infinities, NaNs and signed zeros follow the rules listed below.

Top module: `tf19_addsub`

## Requirements
- R1: Bit 18 of each word is the sign, bits 17:10 hold the exponent with bias 127, and bits 9:0 hold the fraction. For finite operands, the result is the exact sum, rounded as in R3, and encoded in that same format.
- R2: When `op_sub` is 1, the sign of `opb` is inverted before the operation. `opa - opb` therefore gives the same result as `opa + (-opb)`.
- R3: Rounding examines only the first bit below the 10 kept fraction bits. If that bit is 0 the value is truncated. If it is 1, one is added to the kept significand and the rest is dropped.
- R4: `flg_inexact` is 1 exactly when any nonzero bit was discarded, either during alignment or during rounding, or when overflow occurs.
- R5: A finite result whose exponent reaches 255 becomes an infinity with the result's sign, encoded as exponent 255 and fraction 0. It sets `flg_overflow` and `flg_inexact`. At most one of invalid, overflow and underflow is set at a time.
- R6: If either operand is a NaN (exponent 255, fraction nonzero), the result is the quiet NaN 0x3FE00 (sign 0, exponent 255, fraction bit 9 set) and all flags are 0.
- R7: When two infinities meet in an effective subtraction, the result is 0x3FE00 and `flg_invalid` is set.
- R8: An exact zero produced by an effective subtraction is +0 (0x00000).
- R9: An exponent field of 0 marks a denormal operand, whose value is fraction × 2^-136. A nonzero finite result that is too small to be normal is encoded with exponent field 0 and sets `flg_underflow`.
- R10: An infinity combined with a finite operand returns that infinity with its effective sign, and no flag is set.
- R11: Adding two zeros of the same effective sign returns a zero of that sign, so -0 + -0 gives 0x40000.
- R12: If rounding carries out of the significand, the exponent goes up by one and the fraction becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 19 | First operand |
| opb | input | 19 | Second operand |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| res | output | 19 | Rounded result |
| flg_invalid | output | 1 | Invalid operation |
| flg_overflow | output | 1 | Result overflowed to infinity |
| flg_underflow | output | 1 | Result is denormal |
| flg_inexact | output | 1 | Result differs from the exact value |

## Verification
The bench compares every output against an exact model that forms the sum as a wide integer, so mistakes in alignment or in the sticky logic cannot cancel out. The directed cases target the places where the datapath usually breaks:
- An exact half-unit tie, where a round-to-even design would round the wrong way.
- A rounding carry out of an all-ones fraction, where a design that forgets to bump the exponent returns a wrong value.
- Subtracting a tiny denormal from 1.0. A design that drops the borrow from the sticky bits returns 1.0 with no inexact flag, or a value one unit too low.
- Massive cancellation, which a wrong leading-zero shift mis-scales.
- Zero-sign rules, where -0 or +0 comes out inverted.
- The crossing between denormal and normal results, where a bad minimum-exponent clamp corrupts the result.

Random pairs with close exponents add coverage of the cancellation paths.

// File: rtl/tf19_addsub.sv
module tf19_addsub (
  input  logic [18:0] opa,
  input  logic [18:0] opb,
  input  logic        op_sub,
  output logic [18:0] res,
  output logic        flg_invalid,
  output logic        flg_overflow,
  output logic        flg_underflow,
  output logic        flg_inexact
);
  localparam logic [18:0] QNAN = 19'h3FE00;
  localparam int XW = 13;

  logic        sb, eff_sub, swap, sl, st, inx_n;
  logic        nan_a, nan_b, inf_a, inf_b;
  logic [7:0]  ea, eb, el, es, elx, esx, d;
  logic [4:0]  dc, lz;
  logic [10:0] ml, ms;
  logic [63:0] shv;
  logic [23:0] aligned;
  logic [24:0] s;
  logic [9:0]  r, sh;
  logic [11:0] kept;

  assign ea = opa[17:10];
  assign eb = opb[17:10];
  assign sb = opb[18] ^ op_sub;
  assign nan_a = (&ea) && (|opa[9:0]);
  assign nan_b = (&eb) && (|opb[9:0]);
  assign inf_a = (&ea) && !(|opa[9:0]);
  assign inf_b = (&eb) && !(|opb[9:0]);
  assign eff_sub = opa[18] ^ sb;
  assign swap = opb[17:0] > opa[17:0];
  assign sl = swap ? sb : opa[18];
  assign el = swap ? eb : ea;
  assign es = swap ? ea : eb;
  assign ml = swap ? {|eb, opb[9:0]} : {|ea, opa[9:0]};
  assign ms = swap ? {|ea, opa[9:0]} : {|eb, opb[9:0]};
  assign elx = {el[7:1], el[0] | ~|el};
  assign esx = {es[7:1], es[0] | ~|es};
  assign d = elx - esx;
  assign dc = (d > 8'd30) ? 5'd30 : d[4:0];
  assign shv = {ms, {XW{1'b0}}, 40'b0} >> dc;
  assign aligned = shv[63:40];

  always_comb begin
    st = |shv[39:0];
    if (eff_sub) s = {1'b0, ml, {XW{1'b0}}} - {1'b0, aligned} - {24'b0, st};
    else         s = {1'b0, ml, {XW{1'b0}}} + {1'b0, aligned};
    r  = {2'b0, elx};
    lz = 5'd24;
    sh = 10'd0;
    if (s[24]) begin
      st = st | s[0];
      s  = {1'b0, s[24:1]};
      r  = r + 10'd1;
    end else begin
      for (int i = 0; i < 24; i++)
        if (s[i]) lz = 5'(23 - i);
      sh = ({5'b0, lz} > r - 10'd1) ? r - 10'd1 : {5'b0, lz};
      s  = s << sh;
      r  = r - sh;
    end
    kept  = {1'b0, s[23:13]} + {11'b0, s[12]};
    inx_n = st | (|s[12:0]);
    if (kept[11]) begin
      kept = {1'b0, kept[11:1]};
      r    = r + 10'd1;
    end

    flg_invalid   = 1'b0;
    flg_overflow  = 1'b0;
    flg_underflow = 1'b0;
    flg_inexact   = 1'b0;
    if (nan_a || nan_b) begin
      res = QNAN;
    end else if (inf_a && inf_b) begin
      if (eff_sub) begin
        res = QNAN;
        flg_invalid = 1'b1;
      end else begin
        res = {opa[18], 8'hFF, 10'h0};
      end
    end else if (inf_a) begin
      res = {opa[18], 8'hFF, 10'h0};
    end else if (inf_b) begin
      res = {sb, 8'hFF, 10'h0};
    end else if (kept == 12'd0) begin
      res = {eff_sub ? 1'b0 : sl, 18'h0};
    end else if (kept[10] && r >= 10'd255) begin
      res = {sl, 8'hFF, 10'h0};
      flg_overflow = 1'b1;
      flg_inexact  = 1'b1;
    end else begin
      res = {sl, kept[10] ? r[7:0] : 8'h00, kept[9:0]};
      flg_underflow = !kept[10];
      flg_inexact   = inx_n;
    end

    if (flg_overflow)
      p_ovf_is_inf_r5: assert (res[17:0] == {8'hFF, 10'h0} && flg_inexact);
    p_one_hard_flag_r5: assert ($countones({flg_invalid, flg_overflow, flg_underflow}) <= 1);
    if (flg_invalid)
      p_invalid_qnan_r7: assert (res == QNAN);
    if (res[17:10] == 8'hFF && res[9:0] != 10'h0)
      p_nan_source_r6: assert (nan_a || nan_b || flg_invalid);
    if (flg_underflow)
      p_tiny_denorm_r9: assert (res[17:10] == 8'h00 && res[9:0] != 10'h0 && !flg_inexact);
    if (eff_sub && !(&ea) && !(&eb) && res[17:0] == 18'h0)
      p_cancel_pos_zero_r8: assert (!res[18]);
  end
endmodule

// File: tb/test_tf19_addsub.sv
module test_tf19_addsub;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [18:0] opa = '0, opb = '0;
  logic op_sub = 1'b0;
  logic [18:0] res;
  logic f_inv, f_ovf, f_unf, f_inx;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'h1234_5677;

  always #(CLK_PERIOD/2) clk = ~clk;

  tf19_addsub i_tf19_addsub (
    .opa(opa), .opb(opb), .op_sub(op_sub), .res(res),
    .flg_invalid(f_inv), .flg_overflow(f_ovf),
    .flg_underflow(f_unf), .flg_inexact(f_inx)
  );

  function automatic void model(input logic [18:0] a, input logic [18:0] b,
                                input logic sub, output logic [18:0] r,
                                output logic [3:0] fl);
    logic sa, sbx, sg, g;
    logic [7:0] ea, eb;
    logic [299:0] A, B, S, mask;
    logic [11:0] kept;
    int p, e, sh;
    sa = a[18]; sbx = b[18] ^ sub; ea = a[17:10]; eb = b[17:10];
    fl = 4'b0;
    if ((ea == 8'hFF && a[9:0] != 0) || (eb == 8'hFF && b[9:0] != 0)) begin
      r = 19'h3FE00; return;
    end
    if (ea == 8'hFF && eb == 8'hFF) begin
      if (sa != sbx) begin r = 19'h3FE00; fl = 4'b1000; end
      else r = {sa, 8'hFF, 10'h0};
      return;
    end
    if (ea == 8'hFF) begin r = {sa, 8'hFF, 10'h0}; return; end
    if (eb == 8'hFF) begin r = {sbx, 8'hFF, 10'h0}; return; end
    A = 300'({ea != 0, a[9:0]}) << ((ea == 0) ? 0 : int'(ea) - 1);
    B = 300'({eb != 0, b[9:0]}) << ((eb == 0) ? 0 : int'(eb) - 1);
    if (sa == sbx) begin S = A + B; sg = sa; end
    else if (A >= B) begin S = A - B; sg = sa; end
    else begin S = B - A; sg = sbx; end
    if (S == 0) begin r = {(sa == sbx) ? sa : 1'b0, 18'h0}; return; end
    p = 0;
    for (int i = 0; i < 300; i++) if (S[i]) p = i;
    if (p < 10) begin
      r = {sg, 8'h00, S[9:0]}; fl = 4'b0010; return;
    end
    e = p - 9; sh = p - 10;
    kept = 12'(S >> sh);
    g = (sh > 0) ? S[sh-1] : 1'b0;
    mask = (300'd1 << sh) - 300'd1;
    fl[0] = (S & mask) != 0;
    kept = kept + 12'(g);
    if (kept == 12'd2048) begin kept = 12'd1024; e = e + 1; end
    if (e >= 255) begin r = {sg, 8'hFF, 10'h0}; fl = 4'b0101; end
    else r = {sg, 8'(e), kept[9:0]};
  endfunction

  task automatic check(input logic [18:0] a, input logic [18:0] b, input logic sub,
                       input string tag, input bit use_lit = 0,
                       input logic [18:0] lit = '0, input logic [3:0] litfl = '0);
    logic [18:0] er; logic [3:0] ef;
    @(posedge clk);
    opa = a; opb = b; op_sub = sub;
    @(negedge clk);
    model(a, b, sub, er, ef);
    if (use_lit) begin er = lit; ef = litfl; end
    n_chk++;
    if (res !== er || {f_inv, f_ovf, f_unf, f_inx} !== ef) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sub=%0d actual res=%h fl=%b expected res=%h fl=%b",
               tag, a, b, sub, res, {f_inv, f_ovf, f_unf, f_inx}, er, ef);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [18:0] a, b;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (res !== 19'h0 || {f_inv, f_ovf, f_unf, f_inx} !== 4'b0) begin
      n_bad++;
      $display("FAIL R1 reset-state actual %h expected 00000", res);
    end
    // R1 literal values
    check(19'h1FC00, 19'h1FC00, 0, "R1 1+1", 1, 19'h20000, 4'b0000);
    check(19'h1FC00, 19'h20000, 0, "R1 1+2", 1, 19'h20200, 4'b0000);
    // R2 subtract flips sign of opb
    check(19'h20200, 19'h1FC00, 1, "R2 3-1", 1, 19'h20000, 4'b0000);
    check(19'h1FC00, 19'h5FC00, 1, "R2 1-(-1)", 1, 19'h20000, 4'b0000);
    check(19'h1FC00, 19'h1FC01, 1, "R2 cancellation", 1, 19'h5D400, 4'b0000);
    // R3 tie rounds up; below tie truncates
    check(19'h1FC00, 19'h1D000, 0, "R3 half-ulp", 1, 19'h1FC01, 4'b0001);
    check(19'h1FC00, 19'h1CC00, 0, "R3 quarter-ulp", 1, 19'h1FC00, 4'b0001);
    // R4 inexact from far alignment and borrow through sticky
    check(19'h1FC00, 19'h1AC00, 0, "R4 tiny add", 1, 19'h1FC00, 4'b0001);
    check(19'h1FC00, 19'h00001, 1, "R4 1-denorm", 1, 19'h1FC00, 4'b0001);
    check(19'h1FC00, 19'h00001, 0, "R4 1+denorm", 1, 19'h1FC00, 4'b0001);
    // R12 rounding carry
    check(19'h1FFFF, 19'h1D000, 0, "R12 carry", 1, 19'h20000, 4'b0001);
    // R5 overflow
    check(19'h3FBFF, 19'h3FBFF, 0, "R5 max+max", 1, 19'h3FC00, 4'b0101);
    check(19'h7FBFF, 19'h3CC00, 1, "R5 round-to-inf", 1, 19'h7FC00, 4'b0101);
    // R6 NaN inputs
    check(19'h3FC01, 19'h1FC00, 0, "R6 nan a", 1, 19'h3FE00, 4'b0000);
    check(19'h1FC00, 19'h7FE05, 1, "R6 nan b", 1, 19'h3FE00, 4'b0000);
    // R7 invalid
    check(19'h3FC00, 19'h3FC00, 1, "R7 inf-inf", 1, 19'h3FE00, 4'b1000);
    check(19'h3FC00, 19'h7FC00, 0, "R7 inf+-inf", 1, 19'h3FE00, 4'b1000);
    check(19'h7FC00, 19'h7FC00, 0, "R7 -inf+-inf", 1, 19'h7FC00, 4'b0000);
    // R8 exact cancellation gives +0
    check(19'h5FC00, 19'h5FC00, 1, "R8 -1-(-1)", 1, 19'h00000, 4'b0000);
    check(19'h40000, 19'h40000, 1, "R8 -0-(-0)", 1, 19'h00000, 4'b0000);
    check(19'h40000, 19'h00000, 0, "R8 -0+0", 1, 19'h00000, 4'b0000);
    // R9 denormals
    check(19'h00001, 19'h00001, 0, "R9 den+den", 1, 19'h00002, 4'b0010);
    check(19'h003FF, 19'h00001, 0, "R9 to normal", 1, 19'h00400, 4'b0000);
    check(19'h00400, 19'h00001, 1, "R9 to denorm", 1, 19'h003FF, 4'b0010);
    check(19'h00C00, 19'h00BFF, 1, "R9 near-min cancel", 0);
    // R10 infinities with finite values
    check(19'h3FC00, 19'h1FC00, 1, "R10 inf-1", 1, 19'h3FC00, 4'b0000);
    check(19'h1FC00, 19'h3FC00, 1, "R10 1-inf", 1, 19'h7FC00, 4'b0000);
    // R11 signed zero addition
    check(19'h40000, 19'h40000, 0, "R11 -0+-0", 1, 19'h40000, 4'b0000);
    check(19'h40000, 19'h00000, 1, "R11 -0-0", 1, 19'h40000, 4'b0000);
    // R1 random sweep against exact model
    for (int k = 0; k < 4000; k++) begin
      lfsr = step(lfsr); a = lfsr[18:0];
      lfsr = step(lfsr); b = lfsr[18:0];
      if (k % 2 == 0) b[17:10] = a[17:10] + 8'(lfsr[20:19]) - 8'd1;
      lfsr = step(lfsr);
      check(a, b, lfsr[5], "R1 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule